// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Sequencer

This block sits in a memory controller and decides, on every clock, the registered clock-enable level and the command slot sent to a DDR2-style memory. It moves the memory between normal operation, power down (precharge or active, depending on whether any bank is open) and self refresh. It does so in response to level-sensitive sleep and wake requests, a flag that all banks are idle, and a flag that a read, write, mode-register set or precharge is in progress.

The action at each edge is chosen from the clock-enable level already registered and the level being registered now. A falling pair is an entry, a low pair keeps the low-power mode, and a rising pair is an exit. Every new level is held for a minimum number of edges. Self-refresh exit is followed by a window in which only NOP may be sent, and by a longer window before reads are allowed. Both are reported through ready flags. Power down has a bounded residency, so that refresh can still be scheduled. A request that is illegal in the current mode is dropped and raises a one-cycle error pulse.

Top module: `cke_power_seq`

## Requirements
- R1: While reset is asserted and after it is released, until the first action: cke_o is 0, mode_o is 2'b01 (precharge power down), cmd_o is 2'b00 (NOP), and rdy_cmd_o, rdy_rd_o and err_o are 0.
- R2: A new cke_o level is held for at least HOLD_CYC (3) rising edges before it can change. The reset level counts from the first edge after release. A sleep or wake request sampled while the hold is not met is ignored, and err_o pulses for one cycle.
- R3: pd_req_i in normal mode (mode 2'b00), with the hold met and no operation busy, drives cke_o low at that edge with cmd_o NOP. mode_o becomes 2'b01 if banks_idle_i is 1, or 2'b10 (active power down) if it is 0.
- R4: sr_req_i in normal mode with banks_idle_i high drives cke_o low, sets mode_o to 2'b11 and puts REFRESH (cmd_o 2'b01) in the same cycle, for exactly one cycle. sr_req_i takes priority over pd_req_i.
- R5: sr_req_i while banks_idle_i is 0 is ignored, even with pd_req_i also high, and err_o pulses.
- R6: While op_busy_i is high, a sleep request waits without error. Entry happens at the first edge where op_busy_i is low.
- R7: wake_req_i in power down, with the hold met, drives cke_o high with cmd_o NOP and mode_o 2'b00. Both ready flags rise at the same edge.
- R8: After a self-refresh exit edge, rdy_cmd_o rises XNR_CYC (10) edges later and rdy_rd_o rises XRD_CYC (200) edges later. A sleep request made before rdy_cmd_o rises waits without error.
- R9: Power down entered at edge E is left without any request at edge E+PD_MAX+1 (PD_MAX is 40). The exit follows R7.
- R10: wake_req_i in normal mode, or a sleep request while cke_o is low, is ignored and err_o pulses.
- R11: rdy_cmd_o and rdy_rd_o are 0 whenever cke_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Request to enter power down |
| sr_req_i | input | 1 | Request to enter self refresh |
| wake_req_i | input | 1 | Request to leave a low-power mode |
| banks_idle_i | input | 1 | All banks are precharged |
| op_busy_i | input | 1 | Read, write, mode-register set or precharge in progress |
| cke_o | output | 1 | Registered clock-enable |
| cmd_o | output | 2 | Command slot: 00 NOP, 01 REFRESH |
| mode_o | output | 2 | 00 normal, 01 precharge power down, 10 active power down, 11 self refresh |
| rdy_cmd_o | output | 1 | Non-read commands allowed |
| rdy_rd_o | output | 1 | Reads allowed |
| err_o | output | 1 | One-cycle pulse for an ignored illegal request |

## Verification
Power-down requests are tried with the banks both idle and open, which separates the two power-down flavours. Self-refresh requests are tried with a bank open and with pd_req_i also raised, which exposes the refresh guard and the request priority. Requests placed one edge inside the hold window and requests placed with op_busy_i high separate error-and-drop from silent waiting. A long quiet power down and a self-refresh exit counted edge by edge pin the residency limit and both ready windows to their exact edge.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;
  typedef enum logic [1:0] {
    MODE_NORM   = 2'b00,
    MODE_PD_PRE = 2'b01,
    MODE_PD_ACT = 2'b10,
    MODE_SREF   = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_REF = 2'b01
  } cmd_e;
endpackage

// File: rtl/cke_sat_ctr.sv
module cke_sat_ctr #(
  parameter int MAX = 3,
  localparam int W  = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (ld_i)                        cnt_o <= ld_val_i;
    else if (en_i && cnt_o != W'(MAX))    cnt_o <= cnt_o + W'(1);
  end

  // counter never passes its limit (guards hold, window and residency, R2 R8 R9)
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= W'(MAX));
endmodule

// File: rtl/cke_power_seq.sv
module cke_power_seq
  import cke_seq_pkg::*;
#(
  parameter int HOLD_CYC = 3,
  parameter int XNR_CYC  = 10,
  parameter int XRD_CYC  = 200,
  parameter int PD_MAX   = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       wake_req_i,
  input  logic       banks_idle_i,
  input  logic       op_busy_i,
  output logic       cke_o,
  output logic [1:0] cmd_o,
  output logic [1:0] mode_o,
  output logic       rdy_cmd_o,
  output logic       rdy_rd_o,
  output logic       err_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int WW = $clog2(XRD_CYC + 1);
  localparam int RW = $clog2(PD_MAX + 1);

  logic   cke_q, cke_d, err_q, err_d;
  cmd_e   cmd_q, cmd_d;
  pmode_e mode_q, mode_d;
  logic   enter_go, exit_go;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] win_cnt;
  logic [RW-1:0] res_cnt;
  logic   hold_ok, res_full, in_pd, sleep_req;

  assign hold_ok   = hold_cnt == HW'(HOLD_CYC);
  assign res_full  = res_cnt == RW'(PD_MAX);
  assign in_pd     = (mode_q == MODE_PD_PRE) || (mode_q == MODE_PD_ACT);
  assign sleep_req = pd_req_i || sr_req_i;
  assign rdy_cmd_o = (mode_q == MODE_NORM) && (win_cnt >= WW'(XNR_CYC));
  assign rdy_rd_o  = (mode_q == MODE_NORM) && (win_cnt == WW'(XRD_CYC));

  // minimum level hold: reload to 1 on every cke change
  cke_sat_ctr #(.MAX(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .ld_i(cke_d != cke_q), .ld_val_i(HW'(1)), .en_i(1'b1),
    .cnt_o(hold_cnt));

  // exit window: from 0 after self refresh, preset full after power down
  cke_sat_ctr #(.MAX(XRD_CYC)) u_win (
    .clk_i, .rst_ni, .ld_i(exit_go),
    .ld_val_i((mode_q == MODE_SREF) ? WW'(0) : WW'(XRD_CYC)),
    .en_i(mode_q == MODE_NORM), .cnt_o(win_cnt));

  // power-down residency
  cke_sat_ctr #(.MAX(PD_MAX)) u_res (
    .clk_i, .rst_ni, .ld_i(enter_go), .ld_val_i(RW'(0)), .en_i(in_pd),
    .cnt_o(res_cnt));

  always_comb begin
    cke_d    = cke_q;
    mode_d   = mode_q;
    cmd_d    = CMD_NOP;
    err_d    = 1'b0;
    enter_go = 1'b0;
    exit_go  = 1'b0;
    if (cke_q) begin
      if (wake_req_i) err_d = 1'b1;
      if (sleep_req) begin
        if (sr_req_i && !banks_idle_i) err_d = 1'b1;
        else if (!hold_ok)             err_d = 1'b1;
        else if (!op_busy_i && rdy_cmd_o) begin
          enter_go = 1'b1;
          cke_d    = 1'b0;
          if (sr_req_i) begin
            mode_d = MODE_SREF;
            cmd_d  = CMD_REF;
          end else begin
            mode_d = banks_idle_i ? MODE_PD_PRE : MODE_PD_ACT;
          end
        end
      end
    end else begin
      if (sleep_req) err_d = 1'b1;
      if (wake_req_i || (in_pd && res_full)) begin
        if (!hold_ok) begin
          if (wake_req_i) err_d = 1'b1;
        end else begin
          exit_go = 1'b1;
          cke_d   = 1'b1;
          mode_d  = MODE_NORM;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b0;
      mode_q <= MODE_PD_PRE;
      cmd_q  <= CMD_NOP;
      err_q  <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      mode_q <= mode_d;
      cmd_q  <= cmd_d;
      err_q  <= err_d;
    end
  end

  assign cke_o  = cke_q;
  assign cmd_o  = cmd_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_hold_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o != $past(cke_o)) |-> $past(hold_ok));
  p_sref_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (!cke_o && mode_o == MODE_SREF && $past(banks_idle_i)));
  p_entry_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> !$past(op_busy_i));
  p_exit_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == CMD_NOP && mode_o == MODE_NORM));
  p_rd_after_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_rd_o |-> rdy_cmd_o);
  p_wake_in_norm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cke_o) && cke_o && $past(wake_req_i)) |-> err_o);
  p_low_no_rdy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (!rdy_cmd_o && !rdy_rd_o));
endmodule

// File: tb/sim_cke_power_seq.sv
module sim_cke_power_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 0, sr_req = 0, wake = 0, idle = 1, busy = 0;
  logic cke, rdy_cmd, rdy_rd, err;
  logic [1:0] cmd, mode;
  int total = 0, fails = 0;

  localparam int XNR = 10, XRD = 200, PDM = 40;

  always #10 clk = ~clk;

  cke_power_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .sr_req_i(sr_req),
    .wake_req_i(wake), .banks_idle_i(idle), .op_busy_i(busy),
    .cke_o(cke), .cmd_o(cmd), .mode_o(mode), .rdy_cmd_o(rdy_cmd),
    .rdy_rd_o(rdy_rd), .err_o(err));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 cke", cke, 0); chk("R1 mode", mode, 2'b01); chk("R1 cmd", cmd, 0);
    chk("R1 rdy", {rdy_cmd, rdy_rd, err}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_wake_after_reset();
    wake = 1; tick(); wake = 0;
    chk("R2 early wake err", err, 1); chk("R2 early wake cke", cke, 0);
    tick(); tick();
    wake = 1; tick(); wake = 0;
    chk("R7 cke", cke, 1); chk("R7 mode", mode, 0); chk("R7 cmd", cmd, 0);
    chk("R7 rdy", {rdy_cmd, rdy_rd}, 2'b11); chk("R7 err", err, 0);
  endtask

  task automatic t_active_pd();
    pd_req = 1; idle = 0; tick(); pd_req = 0;
    chk("R2 early sleep err", err, 1); chk("R2 early sleep cke", cke, 1);
    tick();
    pd_req = 1; tick(); pd_req = 0;
    chk("R3 cke", cke, 0); chk("R3 mode act", mode, 2'b10); chk("R3 cmd", cmd, 0);
    chk("R11 rdy low", {rdy_cmd, rdy_rd}, 0);
    tick(); tick();
    sr_req = 1; tick(); sr_req = 0;
    chk("R10 sleep in pd err", err, 1); chk("R10 mode kept", mode, 2'b10);
    chk("R10 cke kept", cke, 0);
    wake = 1; tick(); wake = 0;
    chk("R7 exit act pd", {cke, mode}, 3'b100);
    tick(); tick(); tick();
    idle = 1;
    wake = 1; tick(); wake = 0;
    chk("R10 wake in norm err", err, 1); chk("R10 norm kept", cke, 1);
  endtask

  task automatic t_busy_and_residency();
    busy = 1; pd_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 busy wait cke", cke, 1); chk("R6 busy no err", err, 0);
    end
    busy = 0; tick(); pd_req = 0;
    chk("R6 entry after busy", cke, 0); chk("R3 mode pre", mode, 2'b01);
    repeat (PDM) tick();
    chk("R9 still low", cke, 0);
    tick();
    chk("R9 forced exit", cke, 1); chk("R9 rdy", {rdy_cmd, rdy_rd}, 2'b11);
    tick(); tick(); tick();
  endtask

  task automatic t_self_refresh();
    idle = 0; sr_req = 1; tick(); sr_req = 0;
    chk("R5 err", err, 1); chk("R5 cke", cke, 1);
    idle = 0; sr_req = 1; pd_req = 1; tick(); sr_req = 0; pd_req = 0;
    chk("R5 sr+pd ignored", {cke, err}, 2'b11);
    idle = 1; sr_req = 1; pd_req = 1; tick(); sr_req = 0; pd_req = 0;
    chk("R4 cke", cke, 0); chk("R4 mode", mode, 2'b11); chk("R4 cmd ref", cmd, 2'b01);
    tick();
    chk("R4 ref one cycle", cmd, 0); chk("R11 rdy in sr", {rdy_cmd, rdy_rd}, 0);
    tick(); tick();
    wake = 1; tick(); wake = 0;
    chk("R8 exit cke", cke, 1); chk("R8 exit cmd", cmd, 0);
    chk("R8 rdy low", {rdy_cmd, rdy_rd}, 0);
    repeat (XNR - 1) tick();
    chk("R8 rdy_cmd before", rdy_cmd, 0);
    pd_req = 1; tick(); pd_req = 0;
    chk("R8 sleep waits", {cke, err}, 2'b10); chk("R8 rdy_cmd at window", rdy_cmd, 1);
    repeat (XRD - XNR - 1) tick();
    chk("R8 rdy_rd before", rdy_rd, 0);
    tick();
    chk("R8 rdy_rd at window", rdy_rd, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wake_after_reset();
    t_active_pd();
    t_busy_and_residency();
    t_self_refresh();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule